// File: doc/BRIEF.md
# MMU Protection-Fault State Capture Unit

This unit sits next to an address-translation lookup and saves processor context when the lookup signals an access-rights violation. On the clock edge where the violation strobe is high, the unit performs one atomic update. It stores the faulting address and its page number. It records an event code that tells loads from stores. It saves the resume address and the old status word. It moves the core into privileged, exception-blocked, alternate-bank operation. It records which way of the translation buffer produced the hit.

The unit owns the status register. A return-from-exception pulse puts the saved status word back and presents the saved resume address as the return target. A software write port can load any captured register, so a handler can restore or adjust the values. A violation that arrives while exceptions are blocked is dropped and reported on a separate double-fault output.

Top module: `esc_unit`

## Requirements
- R1: After synchronous reset, every captured register, the status register, `double_fault` and `ret_valid` read zero.
- R2: An accepted violation writes bits [XLEN-1:PAGE_SHIFT] of `fault_va` (bits 31:10 by default) into the same bits of `xlat_hi` and leaves its lower bits unchanged.
- R3: An accepted violation writes the whole of `fault_va` into `fault_addr`.
- R4: An accepted violation sets `event_code` to 12'h0A0 when `is_store` is 0 (load) and to 12'h0C0 when `is_store` is 1 (store).
- R5: An accepted violation loads `saved_pc` with `cur_pc`. When `in_delay_slot` is 1, it loads `branch_pc` instead.
- R6: An accepted violation copies the status value from before the update into `saved_sr`.
- R7: An accepted violation sets status bit 30 (privileged mode), bit 29 (register bank) and bit 28 (exception block), and keeps every other status bit.
- R8: An accepted violation writes `fault_way` into `repl_way`.
- R9: A violation strobe that arrives while status bit 28 is 1 changes no register. It raises `double_fault` for exactly one cycle, in the cycle after the strobe.
- R10: A `rte_pulse` copies `saved_sr` into the status register. In the next cycle, `ret_valid` is high for one cycle and `ret_target` equals `saved_pc`.
- R11: A software write with `sw_we` high loads `sw_wdata` into the register chosen by `sw_sel`. The encoding is 0 `xlat_hi`, 1 `fault_addr`, 2 `event_code` (low 12 bits), 3 `saved_pc`, 4 `saved_sr`, 5 status, 6 `repl_way` (low bits). Code 7 selects nothing.
- R12: Priority per cycle is violation strobe (accepted or blocked), then `rte_pulse`, then software write. A lower-priority request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_strobe | input | 1 | Protection-violation strobe |
| fault_va | input | XLEN | Faulting virtual address |
| is_store | input | 1 | 1 = store access, 0 = load access |
| cur_pc | input | XLEN | Address of the faulting instruction |
| in_delay_slot | input | 1 | Fault occurred in a delay slot |
| branch_pc | input | XLEN | Address of the related delayed branch |
| fault_way | input | log2(WAYS) | Way that produced the matching entry |
| rte_pulse | input | 1 | Return-from-exception request |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 3 | Software write register select |
| sw_wdata | input | XLEN | Software write data |
| xlat_hi | output | XLEN | Translation-high register |
| fault_addr | output | XLEN | Fault-address register |
| event_code | output | 12 | Exception-event code register |
| saved_pc | output | XLEN | Saved program counter |
| saved_sr | output | 32 | Saved status register |
| status | output | 32 | Status register |
| repl_way | output | log2(WAYS) | Replacement-way field |
| double_fault | output | 1 | Pulse: violation dropped while blocked |
| ret_valid | output | 1 | Pulse: return target valid |
| ret_target | output | XLEN | Return address (equals `saved_pc`) |

## Verification
Every register of this unit drives a port directly, so a wrong capture shows up one cycle after the edge that caused it. A corrupted status word is different, because it changes later decisions. A wrongly cleared block bit lets a second violation through instead of raising `double_fault`. A wrongly saved status word surfaces only at the next return-from-exception, possibly many cycles later. For that reason the bench compares every output against a reference model on every cycle. The stimulus chains violations, returns and software writes so that stale state is always consumed again.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int SR_W    = 32;
    localparam int EVT_W   = 12;
    localparam int SR_MD   = 30;
    localparam int SR_RB   = 29;
    localparam int SR_BL   = 28;

    localparam logic [EVT_W-1:0] EVT_LOAD_VIOL  = 12'h0A0;
    localparam logic [EVT_W-1:0] EVT_STORE_VIOL = 12'h0C0;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_EXC  = 2'd1,
        ACT_RTE  = 2'd2,
        ACT_SW   = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        SEL_XHI   = 3'd0,
        SEL_FADDR = 3'd1,
        SEL_EVT   = 3'd2,
        SEL_SPC   = 3'd3,
        SEL_SSR   = 3'd4,
        SEL_SR    = 3'd5,
        SEL_RC    = 3'd6,
        SEL_NONE  = 3'd7
    } sel_e;

    typedef struct packed {
        act_e act;
        logic dbl;
    } decision_t;

    function automatic logic [EVT_W-1:0] viol_code(input logic store);
        return store ? EVT_STORE_VIOL : EVT_LOAD_VIOL;
    endfunction

    function automatic logic [SR_W-1:0] enter_handler(input logic [SR_W-1:0] sr);
        logic [SR_W-1:0] r;
        r        = sr;
        r[SR_MD] = 1'b1;
        r[SR_RB] = 1'b1;
        r[SR_BL] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/esc_arbiter.sv
module esc_arbiter
    import esc_pkg::*;
(
    input  logic      strobe,
    input  logic      blocked,
    input  logic      rte,
    input  logic      sw_we,
    output decision_t dec
);
    always_comb begin
        dec.act = ACT_NONE;
        dec.dbl = 1'b0;
        if (strobe) begin
            if (blocked) dec.dbl = 1'b1;
            else         dec.act = ACT_EXC;
        end else if (rte) begin
            dec.act = ACT_RTE;
        end else if (sw_we) begin
            dec.act = ACT_SW;
        end
    end
endmodule

// File: rtl/esc_fault_regs.sv
module esc_fault_regs
    import esc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int PAGE_SHIFT = 10,
    parameter int RC_W       = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  act_e                act,
    input  logic [XLEN-1:0]     fault_va,
    input  logic                is_store,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                in_delay_slot,
    input  logic [XLEN-1:0]     branch_pc,
    input  logic [RC_W-1:0]     fault_way,
    input  sel_e                sw_sel,
    input  logic [XLEN-1:0]     sw_wdata,
    output logic [XLEN-1:0]     xlat_hi,
    output logic [XLEN-1:0]     fault_addr,
    output logic [EVT_W-1:0]    event_code,
    output logic [XLEN-1:0]     saved_pc,
    output logic [RC_W-1:0]     repl_way
);
    localparam int VPN_W = XLEN - PAGE_SHIFT;

    logic [XLEN-1:0] resume_pc;
    assign resume_pc = in_delay_slot ? branch_pc : cur_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            xlat_hi    <= '0;
            fault_addr <= '0;
            event_code <= '0;
            saved_pc   <= '0;
            repl_way   <= '0;
        end else begin
            case (act)
                ACT_EXC: begin
                    xlat_hi[XLEN-1:PAGE_SHIFT] <= fault_va[XLEN-1:PAGE_SHIFT];
                    fault_addr <= fault_va;
                    event_code <= viol_code(is_store);
                    saved_pc   <= resume_pc;
                    repl_way   <= fault_way;
                end
                ACT_SW: begin
                    case (sw_sel)
                        SEL_XHI:   xlat_hi    <= sw_wdata;
                        SEL_FADDR: fault_addr <= sw_wdata;
                        SEL_EVT:   event_code <= sw_wdata[EVT_W-1:0];
                        SEL_SPC:   saved_pc   <= sw_wdata;
                        SEL_RC:    repl_way   <= sw_wdata[RC_W-1:0];
                        default:   ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assert_vpn_R2: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC |=> xlat_hi[XLEN-1:PAGE_SHIFT] == $past(fault_va[XLEN-1:PAGE_SHIFT])
                           && xlat_hi[PAGE_SHIFT-1:0] == $past(xlat_hi[PAGE_SHIFT-1:0]));
    assert_faddr_R3: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC |=> fault_addr == $past(fault_va));
    assert_code_R4: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC |=> (event_code == EVT_LOAD_VIOL || event_code == EVT_STORE_VIOL)
                           && ((event_code == EVT_STORE_VIOL) == $past(is_store)));
    assert_spc_R5: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC && in_delay_slot |=> saved_pc == $past(branch_pc));
    assert_way_R8: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC |=> repl_way == $past(fault_way));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        act == ACT_NONE |=> $stable(fault_addr) && $stable(saved_pc) && $stable(event_code));

    localparam int UNUSED_VPN = VPN_W;
endmodule

// File: rtl/esc_status_regs.sv
module esc_status_regs
    import esc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  sel_e             sw_sel,
    input  logic [XLEN-1:0]  sw_wdata,
    output logic [SR_W-1:0]  status,
    output logic [SR_W-1:0]  saved_sr
);
    localparam int CW = (XLEN < SR_W) ? XLEN : SR_W;

    logic [SR_W-1:0] wdata_sr;
    always_comb begin
        wdata_sr = '0;
        wdata_sr[CW-1:0] = sw_wdata[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status   <= '0;
            saved_sr <= '0;
        end else begin
            case (act)
                ACT_EXC: begin
                    saved_sr <= status;
                    status   <= enter_handler(status);
                end
                ACT_RTE: status <= saved_sr;
                ACT_SW: begin
                    if (sw_sel == SEL_SSR) saved_sr <= wdata_sr;
                    if (sw_sel == SEL_SR)  status   <= wdata_sr;
                end
                default: ;
            endcase
        end
    end

    assert_ssr_R6: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC |=> saved_sr == $past(status));
    assert_bits_R7: assert property (@(posedge clk) disable iff (rst)
        act == ACT_EXC |=> status[SR_MD] && status[SR_RB] && status[SR_BL]
                           && status[SR_BL-1:0] == $past(status[SR_BL-1:0]));
    assert_rte_R10: assert property (@(posedge clk) disable iff (rst)
        act == ACT_RTE |=> status == $past(saved_sr));
endmodule

// File: rtl/esc_unit.sv
module esc_unit
    import esc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int PAGE_SHIFT = 10,
    parameter int WAYS       = 4,
    localparam int RC_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               viol_strobe,
    input  logic [XLEN-1:0]    fault_va,
    input  logic               is_store,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic               in_delay_slot,
    input  logic [XLEN-1:0]    branch_pc,
    input  logic [RC_W-1:0]    fault_way,
    input  logic               rte_pulse,
    input  logic               sw_we,
    input  logic [2:0]         sw_sel,
    input  logic [XLEN-1:0]    sw_wdata,
    output logic [XLEN-1:0]    xlat_hi,
    output logic [XLEN-1:0]    fault_addr,
    output logic [11:0]        event_code,
    output logic [XLEN-1:0]    saved_pc,
    output logic [31:0]        saved_sr,
    output logic [31:0]        status,
    output logic [RC_W-1:0]    repl_way,
    output logic               double_fault,
    output logic               ret_valid,
    output logic [XLEN-1:0]    ret_target
);
    decision_t dec;
    sel_e      sel;

    assign sel = sel_e'(sw_sel);

    esc_arbiter u_arb (
        .strobe  (viol_strobe),
        .blocked (status[SR_BL]),
        .rte     (rte_pulse),
        .sw_we   (sw_we),
        .dec     (dec)
    );

    esc_fault_regs #(
        .XLEN       (XLEN),
        .PAGE_SHIFT (PAGE_SHIFT),
        .RC_W       (RC_W)
    ) u_fault (
        .clk           (clk),
        .rst           (rst),
        .act           (dec.act),
        .fault_va      (fault_va),
        .is_store      (is_store),
        .cur_pc        (cur_pc),
        .in_delay_slot (in_delay_slot),
        .branch_pc     (branch_pc),
        .fault_way     (fault_way),
        .sw_sel        (sel),
        .sw_wdata      (sw_wdata),
        .xlat_hi       (xlat_hi),
        .fault_addr    (fault_addr),
        .event_code    (event_code),
        .saved_pc      (saved_pc),
        .repl_way      (repl_way)
    );

    esc_status_regs #(
        .XLEN (XLEN)
    ) u_sr (
        .clk      (clk),
        .rst      (rst),
        .act      (dec.act),
        .sw_sel   (sel),
        .sw_wdata (sw_wdata),
        .status   (status),
        .saved_sr (saved_sr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            double_fault <= 1'b0;
            ret_valid    <= 1'b0;
        end else begin
            double_fault <= dec.dbl;
            ret_valid    <= (dec.act == ACT_RTE);
        end
    end

    assign ret_target = saved_pc;

    assert_df_R9: assert property (@(posedge clk) disable iff (rst)
        viol_strobe && status[SR_BL] |=> double_fault && $stable(status) && $stable(xlat_hi));
    assert_ret_R10: assert property (@(posedge clk) disable iff (rst)
        rte_pulse && !viol_strobe |=> ret_valid && ret_target == $past(saved_pc));
    assert_prio_R12: assert property (@(posedge clk) disable iff (rst)
        viol_strobe && !status[SR_BL] |=> status[SR_BL] && !ret_valid);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !viol_strobe |=> !double_fault);
endmodule

// File: tb/esc_unit_test.sv
module esc_unit_test;
    localparam int XLEN = 32;
    localparam int PS   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        viol_strobe = 0, is_store = 0, in_delay_slot = 0, rte_pulse = 0, sw_we = 0;
    logic [31:0] fault_va = 0, cur_pc = 0, branch_pc = 0, sw_wdata = 0;
    logic [1:0]  fault_way = 0;
    logic [2:0]  sw_sel = 3'd7;

    logic [31:0] xlat_hi, fault_addr, saved_pc, saved_sr, status, ret_target;
    logic [11:0] event_code;
    logic [1:0]  repl_way;
    logic        double_fault, ret_valid;

    esc_unit uut (
        .clk(clk), .rst(rst), .viol_strobe(viol_strobe), .fault_va(fault_va),
        .is_store(is_store), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
        .branch_pc(branch_pc), .fault_way(fault_way), .rte_pulse(rte_pulse),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .xlat_hi(xlat_hi), .fault_addr(fault_addr), .event_code(event_code),
        .saved_pc(saved_pc), .saved_sr(saved_sr), .status(status),
        .repl_way(repl_way), .double_fault(double_fault), .ret_valid(ret_valid),
        .ret_target(ret_target)
    );

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_xhi = 0, m_fa = 0, m_spc = 0, m_ssr = 0, m_sr = 0;
    logic [11:0] m_evt = 0;
    logic [1:0]  m_rc = 0;
    logic        m_df = 0, m_rv = 0;
    bit          armed = 0;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (rst) begin
            m_xhi = 0; m_fa = 0; m_spc = 0; m_ssr = 0; m_sr = 0;
            m_evt = 0; m_rc = 0; m_df = 0; m_rv = 0;
            armed = 1;
        end else begin
            m_df = 0;
            m_rv = 0;
            if (viol_strobe) begin
                if (m_sr[28]) begin
                    m_df = 1;                                   // R9
                end else begin
                    m_xhi = {fault_va[31:PS], m_xhi[PS-1:0]};   // R2
                    m_fa  = fault_va;                           // R3
                    m_evt = is_store ? 12'h0C0 : 12'h0A0;       // R4
                    m_spc = in_delay_slot ? branch_pc : cur_pc; // R5
                    m_ssr = m_sr;                               // R6
                    m_sr  = m_sr | 32'h7000_0000;               // R7
                    m_rc  = fault_way;                          // R8
                end
            end else if (rte_pulse) begin
                m_sr = m_ssr;                                   // R10
                m_rv = 1;
            end else if (sw_we) begin                           // R11, R12
                case (sw_sel)
                    3'd0: m_xhi = sw_wdata;
                    3'd1: m_fa  = sw_wdata;
                    3'd2: m_evt = sw_wdata[11:0];
                    3'd3: m_spc = sw_wdata;
                    3'd4: m_ssr = sw_wdata;
                    3'd5: m_sr  = sw_wdata;
                    3'd6: m_rc  = sw_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string name, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R2",  "xlat_hi",      xlat_hi,      m_xhi);
            chk("R3",  "fault_addr",   fault_addr,   m_fa);
            chk("R4",  "event_code",   {20'd0, event_code}, {20'd0, m_evt});
            chk("R5",  "saved_pc",     saved_pc,     m_spc);
            chk("R6",  "saved_sr",     saved_sr,     m_ssr);
            chk("R7",  "status",       status,       m_sr);
            chk("R8",  "repl_way",     {30'd0, repl_way}, {30'd0, m_rc});
            chk("R9",  "double_fault", {31'd0, double_fault}, {31'd0, m_df});
            chk("R10", "ret_valid",    {31'd0, ret_valid}, {31'd0, m_rv});
            chk("R10", "ret_target",   ret_target,   m_spc);
        end
    end

    task automatic idle();
        viol_strobe = 0; rte_pulse = 0; sw_we = 0; sw_sel = 3'd7;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic fault(input logic [31:0] va, input logic st, input logic ds,
                         input logic [31:0] pc, input logic [31:0] bpc, input logic [1:0] w);
        idle();
        viol_strobe = 1; fault_va = va; is_store = st; in_delay_slot = ds;
        cur_pc = pc; branch_pc = bpc; fault_way = w;
        cyc();
        idle();
    endtask

    task automatic swr(input logic [2:0] s, input logic [31:0] d);
        idle();
        sw_we = 1; sw_sel = s; sw_wdata = d;
        cyc();
        idle();
    endtask

    task automatic rte();
        idle();
        rte_pulse = 1;
        cyc();
        idle();
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad = bad + 1;
        $display("FAIL watchdog expired actual=%0d cycles expected=completion", cycles);
        finish_up();
    end

    initial begin
        repeat (3) cyc();
        // R1: reset state at the ports
        chk("R1", "status_reset",  status, 32'h0);
        chk("R1", "saved_pc_reset", saved_pc, 32'h0);
        chk("R1", "flags_reset", {30'd0, double_fault, ret_valid}, 32'h0);
        rst = 0;
        cyc();
        // R11: low bits of xlat_hi preset by software so R2 can show they are kept
        swr(3'd0, 32'h0000_03A5);
        swr(3'd5, 32'h0000_00F0);
        // R2-R8: load fault, not in a delay slot
        fault(32'h1234_5678, 1'b0, 1'b0, 32'h8000_0100, 32'h8000_00FC, 2'd2);
        cyc();
        // R9: second fault while blocked
        fault(32'hDEAD_BEEF, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222, 2'd1);
        cyc();
        // R10: return
        rte();
        cyc();
        // R4, R5: store fault in a delay slot
        fault(32'hCAFE_F00D, 1'b1, 1'b1, 32'h0000_4004, 32'h0000_4000, 2'd3);
        // R12: rte and sw write together - rte wins
        idle(); rte_pulse = 1; sw_we = 1; sw_sel = 3'd3; sw_wdata = 32'h5555_5555; cyc(); idle();
        // R12: strobe and sw write together - strobe wins
        idle(); viol_strobe = 1; fault_va = 32'h0ABC_DEF0; is_store = 0; in_delay_slot = 0;
        cur_pc = 32'h0000_9000; fault_way = 0; sw_we = 1; sw_sel = 3'd1; sw_wdata = 32'hFFFF_FFFF;
        cyc(); idle();
        // R12 + R9: blocked strobe with rte still drops rte
        idle(); viol_strobe = 1; rte_pulse = 1; cyc(); idle();
        // R11: every select, including none
        for (int s = 0; s < 8; s++) swr(s[2:0], 32'hA5A5_0000 | s);
        cyc();
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            fault_va = $urandom; cur_pc = $urandom; branch_pc = $urandom;
            is_store = 1'($urandom); in_delay_slot = 1'($urandom); fault_way = 2'($urandom);
            sw_sel = 3'($urandom); sw_wdata = $urandom;
            viol_strobe = (r < 18);
            rte_pulse   = (r >= 12 && r < 30);
            sw_we       = (r >= 25 && r < 70);
            cyc();
        end
        idle();
        repeat (3) cyc();
        finish_up();
    end
endmodule